// File: doc/BRIEF.md
# Calendar Alarm Match Interrupt

This block compares the current minute, hour and either the weekday or the day of the month against three programmable alarm bytes. It holds an alarm flag and drives an interrupt request. The comparison runs only in the cycle in which the timekeeping logic pulses its minute-update strobe. The current time arrives as BCD minute, BCD hour, a one-hot weekday and a BCD date. Each alarm byte has its own mask bit. When that bit is set, the byte's field takes no part in the match. A mode bit selects how the third byte is read: as a weekday bitmap that may hold several days, or as a BCD date.

Software programs the block through a simple write port with a 2-bit address and an 8-bit data word. Addresses 0, 1 and 2 hold the minute, hour and day alarm bytes. Address 3 is the control word. It carries the interrupt enable, the mode select and the flag-clear bit. The interrupt output is a drive-low enable for an open-drain pad: 1 means pull the line low, 0 means release it.

Top module: `alarm_match_irq`

## Requirements
- R1: The alarm flag `af_o` can only become 1 on the clock edge that samples `min_tick_i` high. With the strobe low, matching time values never set it.
- R2: The minute alarm byte (address 0) uses bit 7 as a mask (1 = ignore the field) and bits 6:0 as a BCD minute. With bit 7 at 0, the field matches only when bits 6:0 equal `cur_min_i`.
- R3: The hour alarm byte (address 1) uses bit 7 as a mask and bits 5:0 as a BCD hour. With bit 7 at 0, the field matches only when bits 5:0 equal `cur_hour_i`.
- R4: In date mode (control bit 1 = 1), the day alarm byte (address 2) uses bit 7 as a mask and bits 5:0 as a BCD date. With bit 7 at 0, the field matches only when bits 5:0 equal `cur_mday_i`.
- R5: In weekday mode (control bit 1 = 0), bits 6:0 of the day alarm byte are a weekday bitmap: bit 0 is Sunday and bit 6 is Saturday. Any number of bits may be set. The field matches when the bit for the current one-hot `cur_wday_i` is set in the bitmap.
- R6: With bit 7 set in all three alarm bytes, every minute-update strobe sets the flag.
- R7: A strobe that finds all three fields matching sets `af_o` to 1 on that edge. `irq_drive_o` is 1 exactly when the flag is set and the interrupt enable (control bit 0) is 1.
- R8: A control write with bit 2 at 0 clears `af_o` and releases `irq_drive_o` on the next edge. A control write with bit 2 at 1 leaves `af_o` unchanged.
- R9: Clearing the interrupt enable releases `irq_drive_o` on the next edge while `af_o` stays at 1.
- R10: A control write that clears the flag in the same cycle as a matching strobe leaves `af_o` at 1.
- R11: After reset, all alarm bytes and control bits are 0, and `af_o` and `irq_drive_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| min_tick_i | input | 1 | Minute-update strobe, one cycle |
| cur_min_i | input | 7 | Current minute, BCD |
| cur_hour_i | input | 6 | Current hour, BCD |
| cur_wday_i | input | 7 | Current weekday, one-hot, bit 0 = Sunday |
| cur_mday_i | input | 6 | Current day of month, BCD |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 minute, 1 hour, 2 day, 3 control |
| reg_wdata_i | input | 8 | Register write data |
| af_o | output | 1 | Alarm flag |
| irq_drive_o | output | 1 | Interrupt pull-low enable |

## Verification
A wrong alarm byte or a wrong mode bit shows up as a flag that fails to rise, or that rises on a mismatch. This is visible one edge after the strobe that sampled it. The benches therefore clear the flag, apply a single strobe, and read `af_o` in the next cycle, for every pair of alarm value and current value in each field. A flag or enable register with the wrong update priority shows on `af_o` or `irq_drive_o` one edge after the offending control write or strobe.

// File: rtl/alarm_match_pkg.sv
package alarm_match_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned MIN_W    = 7;
  localparam int unsigned HOUR_W   = 6;
  localparam int unsigned MDAY_W   = 6;
  localparam int unsigned NUM_WDAY = 7;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned MASK_BIT = BYTE_W - 1;

  localparam int unsigned CTL_AIE  = 0;
  localparam int unsigned CTL_MODE = 1;
  localparam int unsigned CTL_FLAG = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_MIN  = 2'd0,
    ADDR_HOUR = 2'd1,
    ADDR_DAY  = 2'd2,
    ADDR_CTRL = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              min_off;
    logic [MIN_W-1:0]  min_val;
    logic              hour_off;
    logic [HOUR_W-1:0] hour_val;
    logic              day_off;
    logic [NUM_WDAY-1:0] day_val;
    logic              aie;
    logic              date_mode;
  } alarm_cfg_t;
endpackage

// File: rtl/alarm_cfg_regs.sv
module alarm_cfg_regs
  import alarm_match_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output alarm_cfg_t        cfg_o,
  output logic              flag_clr_o
);
  alarm_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (we_i) begin
      unique case (reg_addr_e'(addr_i))
        ADDR_MIN: begin
          cfg_q.min_off <= wdata_i[MASK_BIT];
          cfg_q.min_val <= wdata_i[MIN_W-1:0];
        end
        ADDR_HOUR: begin
          cfg_q.hour_off <= wdata_i[MASK_BIT];
          cfg_q.hour_val <= wdata_i[HOUR_W-1:0];
        end
        ADDR_DAY: begin
          cfg_q.day_off <= wdata_i[MASK_BIT];
          cfg_q.day_val <= wdata_i[NUM_WDAY-1:0];
        end
        ADDR_CTRL: begin
          cfg_q.aie       <= wdata_i[CTL_AIE];
          cfg_q.date_mode <= wdata_i[CTL_MODE];
        end
        default: ;
      endcase
    end
  end

  assign cfg_o      = cfg_q;
  // only a 0 in the flag position clears; a 1 is ignored
  assign flag_clr_o = we_i && (reg_addr_e'(addr_i) == ADDR_CTRL) && !wdata_i[CTL_FLAG];
endmodule

// File: rtl/alarm_compare.sv
module alarm_compare
  import alarm_match_pkg::*;
(
  input  alarm_cfg_t          cfg_i,
  input  logic [MIN_W-1:0]    cur_min_i,
  input  logic [HOUR_W-1:0]   cur_hour_i,
  input  logic [NUM_WDAY-1:0] cur_wday_i,
  input  logic [MDAY_W-1:0]   cur_mday_i,
  output logic                hit_o
);
  logic [NUM_WDAY-1:0] wday_and;
  logic min_ok, hour_ok, day_ok, week_eq, date_eq;

  for (genvar d = 0; d < NUM_WDAY; d++) begin : g_wday
    assign wday_and[d] = cfg_i.day_val[d] & cur_wday_i[d];
  end

  assign week_eq = |wday_and;
  assign date_eq = (cfg_i.day_val[MDAY_W-1:0] == cur_mday_i);

  always_comb begin
    min_ok  = cfg_i.min_off  || (cfg_i.min_val  == cur_min_i);
    hour_ok = cfg_i.hour_off || (cfg_i.hour_val == cur_hour_i);
    day_ok  = cfg_i.day_off  || (cfg_i.date_mode ? date_eq : week_eq);
    hit_o   = min_ok && hour_ok && day_ok;
  end
endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic hit_i,
  input  logic clr_i,
  input  logic aie_i,
  output logic af_o,
  output logic irq_o
);
  logic af_q, set;

  assign set = tick_i && hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    af_q <= 1'b0;
    else if (set)   af_q <= 1'b1;  // set wins over a concurrent clear
    else if (clr_i) af_q <= 1'b0;
  end

  assign af_o  = af_q;
  assign irq_o = af_q && aie_i;
endmodule

// File: rtl/alarm_match_irq.sv
module alarm_match_irq
  import alarm_match_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                min_tick_i,
  input  logic [MIN_W-1:0]    cur_min_i,
  input  logic [HOUR_W-1:0]   cur_hour_i,
  input  logic [NUM_WDAY-1:0] cur_wday_i,
  input  logic [MDAY_W-1:0]   cur_mday_i,
  input  logic                reg_we_i,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic [BYTE_W-1:0]   reg_wdata_i,
  output logic                af_o,
  output logic                irq_drive_o
);
  alarm_cfg_t cfg;
  logic flag_clr, hit;

  alarm_cfg_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .cfg_o      (cfg),
    .flag_clr_o (flag_clr)
  );

  alarm_compare u_cmp (
    .cfg_i      (cfg),
    .cur_min_i  (cur_min_i),
    .cur_hour_i (cur_hour_i),
    .cur_wday_i (cur_wday_i),
    .cur_mday_i (cur_mday_i),
    .hit_o      (hit)
  );

  alarm_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (min_tick_i),
    .hit_i  (hit),
    .clr_i  (flag_clr),
    .aie_i  (cfg.aie),
    .af_o   (af_o),
    .irq_o  (irq_drive_o)
  );
endmodule

// File: rtl/alarm_match_irq_chk.sv
module alarm_match_irq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic min_tick_i,
  input logic hit_i,
  input logic clr_i,
  input logic aie_i,
  input logic af_o,
  input logic irq_drive_o
);
  assert_rise_needs_tick_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_o) |-> $past(min_tick_i && hit_i));

  assert_match_sets_flag_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (min_tick_i && hit_i) |=> af_o);

  assert_irq_needs_enable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_drive_o |-> (af_o && aie_i));

  assert_clear_drops_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !(min_tick_i && hit_i)) |=> (!af_o && !irq_drive_o));

  assert_flag_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !(min_tick_i && hit_i)) |=> $stable(af_o));

  assert_disable_releases_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (af_o && !aie_i) |-> !irq_drive_o);

  assert_set_beats_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && min_tick_i && hit_i) |=> af_o);
endmodule

bind alarm_match_irq alarm_match_irq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .min_tick_i  (min_tick_i),
  .hit_i       (hit),
  .clr_i       (flag_clr),
  .aie_i       (cfg.aie),
  .af_o        (af_o),
  .irq_drive_o (irq_drive_o)
);

// File: tb/alarm_match_irq_bench.sv
module alarm_match_irq_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [6:0] cur_min = '0;
  logic [5:0] cur_hour = '0;
  logic [6:0] cur_wday = 7'd1;
  logic [5:0] cur_mday = '0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       af, irq;

  int n_vec = 0;
  int n_bad = 0;
  logic aie_s = 1'b0;
  logic mode_s = 1'b0;

  alarm_match_irq u_alarm_match_irq (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .min_tick_i  (tick),
    .cur_min_i   (cur_min),
    .cur_hour_i  (cur_hour),
    .cur_wday_i  (cur_wday),
    .cur_mday_i  (cur_mday),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .af_o        (af),
    .irq_drive_o (irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] bcd(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  // inputs change on the falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  // control word: bit0 enable, bit1 date mode, bit2 flag (0 clears)
  task automatic ctrl(input logic en, input logic md, input logic fl);
    aie_s = en; mode_s = md;
    wr(2'd3, {5'd0, fl, md, en});
  endtask

  // clear, one strobe, then read the flag one edge later
  task automatic vec(input int mn, input int hr, input int wd, input int md,
                     input logic exp, input string req);
    ctrl(aie_s, mode_s, 1'b0);
    cur_min = bcd(mn)[6:0]; cur_hour = bcd(hr)[5:0];
    cur_wday = 7'(1 << wd); cur_mday = bcd(md)[5:0];
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    chk(req, af, exp);
    chk(req, irq, exp & aie_s);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", af, 1'b0);
    chk("R11", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // reset alarm = minute 00, hour 00, empty weekday mask: never matches
    vec(0, 0, 0, 0, 1'b0, "R11");

    // R5: weekday bitmap sweep, minute and hour masked
    ctrl(1'b1, 1'b0, 1'b0);
    wr(2'd0, 8'h80); wr(2'd1, 8'h80);
    for (int m = 0; m < 128; m++) begin
      wr(2'd2, 8'(m));
      for (int d = 0; d < 7; d++) vec(5, 5, d, 1, m[d], "R5");
    end

    // R4: date mode sweep
    ctrl(1'b1, 1'b1, 1'b0);
    for (int a = 1; a <= 31; a++) begin
      wr(2'd2, bcd(a));
      for (int c = 1; c <= 31; c++) vec(0, 0, 3, c, a == c, "R4");
    end

    // R2: minute sweep, hour and day masked
    wr(2'd1, 8'h80); wr(2'd2, 8'h80);
    for (int a = 0; a < 60; a++) begin
      wr(2'd0, bcd(a));
      for (int c = 0; c < 60; c++) vec(c, 7, 2, 9, a == c, "R2");
    end

    // R3: hour sweep, minute and day masked
    wr(2'd0, 8'h80);
    for (int a = 0; a < 24; a++) begin
      wr(2'd1, bcd(a));
      for (int c = 0; c < 24; c++) vec(33, c, 4, 12, a == c, "R3");
    end

    // R6: all fields masked, every strobe fires
    wr(2'd1, 8'h80);
    for (int c = 0; c < 60; c += 7) vec(c, c % 24, c % 7, 1 + c % 28, 1'b1, "R6");

    // R1: matching values without strobe leave flag low
    ctrl(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      cur_min = bcd(k)[6:0];
      chk("R1", af, 1'b0);
    end

    // R7 / R9 / R8: combined minute+hour+weekday match, enable handling
    ctrl(1'b0, 1'b0, 1'b0);
    wr(2'd0, bcd(45)); wr(2'd1, bcd(17)); wr(2'd2, 8'b0100010);
    vec(45, 17, 5, 1, 1'b1, "R7");
    vec(45, 17, 4, 1, 1'b0, "R7");
    vec(44, 17, 1, 1, 1'b0, "R7");
    vec(45, 17, 1, 1, 1'b1, "R7");
    chk("R7", irq, 1'b0);
    ctrl(1'b1, 1'b0, 1'b1);
    chk("R7", irq, 1'b1);
    chk("R8", af, 1'b1);
    ctrl(1'b0, 1'b0, 1'b1);
    chk("R9", irq, 1'b0);
    chk("R9", af, 1'b1);
    ctrl(1'b1, 1'b0, 1'b1);
    chk("R9", irq, 1'b1);
    ctrl(1'b1, 1'b0, 1'b0);
    chk("R8", af, 1'b0);
    chk("R8", irq, 1'b0);
    ctrl(1'b1, 1'b0, 1'b1);
    chk("R8", af, 1'b0);

    // R10: clear in the same cycle as a matching strobe
    cur_min = bcd(45)[6:0]; cur_hour = bcd(17)[5:0]; cur_wday = 7'b0000010;
    @(negedge clk);
    we = 1'b1; addr = 2'd3; wdata = 8'b0000_0001; tick = 1'b1;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
    chk("R10", af, 1'b1);
    chk("R10", irq, 1'b1);

    finish_run();
  end
endmodule